// File: doc/BRIEF.md
# Three-Modulus Residue-to-Binary Converter

This block turns a residue triple back into an ordinary unsigned binary integer. The three moduli are 2^(2n)-1, 2^(2n) and 2^(2n)+1 for a parameter n, and together they cover every X from 0 up to, but not including, 2^(6n)-2^(2n). The residue modulo 2^(2n) is simply the low 2n bits of X, so the block only has to rebuild the upper part. That upper part, the quotient Q = floor(X / 2^(2n)), is found modulo 2^(4n)-1, which is the product of the two outer moduli. The constants the Chinese remainder theorem needs here are all powers of two, possibly negated, so every product turns into a rotation or an inversion of a 4n-bit word.

Four 4n-bit partial terms are formed from the residues. Two carry-save stages with end-around carry reduce them to two words, and one carry-propagate adder with end-around carry sums those two words. If that adder returns the all-ones pattern, which is the second code for zero, it is replaced by zero. The result is {Q, x2}. It is registered once, and it is qualified by an output valid that follows the input valid one cycle later.

Top module: `rrc_reverse_conv`

## Requirements
- R1: After a synchronous active-high reset, and while no input is marked valid, out_valid is 0.
- R2: out_valid is 1 in exactly those cycles that directly follow a cycle with in_valid at 1 and reset low. This gives a one-cycle latency, and idle input cycles produce no output.
- R3: Bits [2n-1:0] of out_x equal the in_r2 residue presented with that result.
- R4: Bits [6n-1:2n] of out_x equal floor(X/2^(2n)) for every X in 0 .. 2^(6n)-2^(2n)-1, where the inputs are in_r1 = X mod (2^(2n)-1), in_r2 = X mod 2^(2n) and in_r3 = X mod (2^(2n)+1).
- R5: The upper field of out_x is never all ones. For X below 2^(2n) it is exactly zero.
- R6: For n=1, the residues (in_r1, in_r2, in_r3) = (1, 2, 2) give out_x = 22, which is Q = 5.
- R7: in_r3 equal to 2^(2n), which is its top value and sets its most significant bit, is converted correctly. For n=1 the residues (1, 0, 4) give out_x = 4.
- R8: A reset asserted in a cycle where in_valid is 1 wins. out_valid is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Residue triple on the inputs is valid this cycle |
| in_r1 | input | 2N | Residue modulo 2^(2N)-1 |
| in_r2 | input | 2N | Residue modulo 2^(2N) |
| in_r3 | input | 2N+1 | Residue modulo 2^(2N)+1 |
| out_valid | output | 1 | out_x holds a new result |
| out_x | output | 6N | Rebuilt integer {Q, in_r2} |

## Verification
Every X in the dynamic range is converted for both n=1 and n=2, with idle cycles mixed into the stream. A wrong rotation amount or a missing inversion shows up as a wrong quotient for some X, and a latency error shows up in the valid pattern around the bubbles. The smallest values of X, where Q is zero, separate a correct zero fold from an all-ones output. X values whose third residue is 2^(2n) test the otherwise unused top bit of that input. The hand-worked triple (1, 2, 2) and a reset that coincides with a valid input complete the set.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
    function automatic int unsigned half_width(input int unsigned n);
        return 2 * n;
    endfunction

    function automatic int unsigned quot_width(input int unsigned n);
        return 4 * n;
    endfunction

    function automatic int unsigned full_width(input int unsigned n);
        return 6 * n;
    endfunction
endpackage

// File: rtl/rrc_terms.sv
module rrc_terms
    import rrc_pkg::*;
#(
    parameter int unsigned N = 2
) (
    input  logic [half_width(N)-1:0] r1,
    input  logic [half_width(N)-1:0] r2,
    input  logic [half_width(N):0]   r3,
    output logic [quot_width(N)-1:0] t_a,
    output logic [quot_width(N)-1:0] t_b,
    output logic [quot_width(N)-1:0] t_c,
    output logic [quot_width(N)-1:0] t_d
);
    localparam int unsigned HW = half_width(N);
    localparam int unsigned QW = quot_width(N);

    logic [QW-1:0] dup1;
    logic [QW-1:0] ext3;

    // (2^HW + 1) * r1 fits exactly as two copies of r1
    assign dup1 = {r1, r1};
    assign ext3 = {{(QW-HW-1){1'b0}}, r3};

    // 2^(HW-1) * (2^HW+1) * r1 : rotate left by HW-1
    assign t_a = {dup1[QW-HW:0], dup1[QW-1:QW-HW+1]};
    // -2^HW * r2 : shift into upper half, then invert (negation mod 2^QW-1)
    assign t_b = ~{r2, {HW{1'b0}}};
    // +2^(HW-1) * r3 : rotate left by HW-1
    assign t_c = {ext3[QW-HW:0], ext3[QW-1:QW-HW+1]};
    // -2^(QW-1) * r3 : rotate right by one, then invert
    assign t_d = ~{ext3[0], ext3[QW-1:1]};
endmodule

// File: rtl/rrc_csa_eac.sv
module rrc_csa_eac #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] s,
    output logic [W-1:0] cy
);
    logic [W-1:0] maj;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s[i]   = a[i] ^ b[i] ^ c[i];
        assign maj[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
    end

    // carry out of the top bit re-enters at bit 0
    assign cy = {maj[W-2:0], maj[W-1]};
endmodule

// File: rtl/rrc_cpa_eac.sv
module rrc_cpa_eac #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] q
);
    logic [W:0]   full;
    logic [W-1:0] wrap;

    assign full = {1'b0, a} + {1'b0, b};
    assign wrap = full[W-1:0] + {{(W-1){1'b0}}, full[W]};
    // all ones is the redundant zero code of a 2^W-1 modulus
    assign q    = (&wrap) ? '0 : wrap;
endmodule

// File: rtl/rrc_reverse_conv.sv
module rrc_reverse_conv
    import rrc_pkg::*;
#(
    parameter int unsigned N = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [half_width(N)-1:0] in_r1,
    input  logic [half_width(N)-1:0] in_r2,
    input  logic [half_width(N):0]   in_r3,
    output logic                     out_valid,
    output logic [full_width(N)-1:0] out_x
);
    localparam int unsigned HW = half_width(N);
    localparam int unsigned QW = quot_width(N);
    localparam int unsigned XW = full_width(N);
    localparam logic [QW+2:0] MOD_W = {3'b000, {QW{1'b1}}};

    typedef struct packed {
        logic          vld;
        logic [XW-1:0] x;
    } out_t;

    logic [QW-1:0] term_a, term_b, term_c, term_d;
    logic [QW-1:0] s0, c0, s1, c1;
    logic [QW-1:0] quot;
    out_t          out_d, out_q;

    rrc_terms #(.N(N)) u_terms (
        .r1 (in_r1),
        .r2 (in_r2),
        .r3 (in_r3),
        .t_a(term_a),
        .t_b(term_b),
        .t_c(term_c),
        .t_d(term_d)
    );

    rrc_csa_eac #(.W(QW)) u_csa0 (
        .a (term_a),
        .b (term_b),
        .c (term_c),
        .s (s0),
        .cy(c0)
    );

    rrc_csa_eac #(.W(QW)) u_csa1 (
        .a (s0),
        .b (c0),
        .c (term_d),
        .s (s1),
        .cy(c1)
    );

    // R4: the carry-save pair keeps the residue of the four terms
    assert_csa_mod_R4 : assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ((({3'b000, s1} + {3'b000, c1}) % MOD_W) ==
                      (({3'b000, term_a} + {3'b000, term_b} +
                        {3'b000, term_c} + {3'b000, term_d}) % MOD_W)));

    rrc_cpa_eac #(.W(QW)) u_cpa (
        .a(s1),
        .b(c1),
        .q(quot)
    );

    // R4: final adder yields the canonical residue of its two inputs
    assert_cpa_mod_R4 : assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ({3'b000, quot} == (({3'b000, s1} + {3'b000, c1}) % MOD_W)));

    always_comb begin
        out_d     = out_q;
        out_d.vld = in_valid;
        if (in_valid) begin
            out_d.x = {quot, in_r2};
        end
        if (rst) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign out_valid = out_q.vld;
    assign out_x     = out_q.x;

    assert_valid_follows_R2 : assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_bubble_R2 : assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_low_bits_R3 : assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_x[HW-1:0] == $past(in_r2)));

    assert_upper_not_ones_R5 : assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_x[XW-1:HW] != {QW{1'b1}}));

    assert_reset_clears_R8 : assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

// File: tb/sim_rrc_reverse_conv.sv
module sim_rrc_reverse_conv;
    localparam time CLK_T = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    int          checks = 0;
    int          errors = 0;

    // u0: n = 2, u1: n = 1
    logic        v0 = 1'b0, v1 = 1'b0;
    logic [3:0]  a0 = '0, b0 = '0;
    logic [4:0]  c0 = '0;
    logic [1:0]  a1 = '0, b1 = '0;
    logic [2:0]  c1 = '0;
    logic        ov0, ov1;
    logic [11:0] ox0;
    logic [5:0]  ox1;

    int q0[$], t0[$], q1[$], t1[$];

    always #(CLK_T/2) clk = ~clk;

    rrc_reverse_conv #(.N(2)) u0 (
        .clk(clk), .rst(rst), .in_valid(v0),
        .in_r1(a0), .in_r2(b0), .in_r3(c0),
        .out_valid(ov0), .out_x(ox0)
    );

    rrc_reverse_conv #(.N(1)) u1 (
        .clk(clk), .rst(rst), .in_valid(v1),
        .in_r1(a1), .in_r2(b1), .in_r3(c1),
        .out_valid(ov1), .out_x(ox1)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic send0(input int x);
        @(negedge clk);
        v0 = 1'b1;
        a0 = 4'(x % 15);
        b0 = 4'(x % 16);
        c0 = 5'(x % 17);
        q0.push_back(x);
        t0.push_back(0);
    endtask

    task automatic send1(input int r1, input int r2, input int r3, input int x, input int tag);
        @(negedge clk);
        v1 = 1'b1;
        a1 = 2'(r1);
        b1 = 2'(r2);
        c1 = 3'(r3);
        q1.push_back(x);
        t1.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        v0 = 1'b0;
        v1 = 1'b0;
    endtask

    // scoreboard monitor for u0 (n = 2)
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (!rst) begin
                if (q0.size() > 0) begin
                    int x;
                    int tg;
                    x  = q0.pop_front();
                    tg = t0.pop_front();
                    checks++;
                    if (ov0 !== 1'b1) begin
                        errors++;
                        $display("FAIL R2 n=2 valid: got %0b expected 1", ov0);
                    end
                    checks++;
                    if (ox0[3:0] !== 4'(x % 16)) begin
                        errors++;
                        $display("FAIL R3 n=2 X=%0d low: got %0d expected %0d", x, ox0[3:0], x % 16);
                    end
                    checks++;
                    if (ox0[11:4] !== 8'(x / 16)) begin
                        errors++;
                        if (x < 16)
                            $display("FAIL R5 n=2 X=%0d high: got %0d expected %0d", x, ox0[11:4], x / 16);
                        else
                            $display("FAIL R4 n=2 X=%0d high: got %0d expected %0d", x, ox0[11:4], x / 16);
                    end
                    if (tg != 0) $display("note tag %0d", tg);
                end else begin
                    checks++;
                    if (ov0 !== 1'b0) begin
                        errors++;
                        $display("FAIL R2 n=2 bubble valid: got %0b expected 0", ov0);
                    end
                end
            end
        end
    end

    // scoreboard monitor for u1 (n = 1)
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (!rst) begin
                if (q1.size() > 0) begin
                    int x;
                    int tg;
                    x  = q1.pop_front();
                    tg = t1.pop_front();
                    checks++;
                    if (ov1 !== 1'b1) begin
                        errors++;
                        $display("FAIL R2 n=1 valid: got %0b expected 1", ov1);
                    end
                    checks++;
                    if (ox1 !== 6'(x)) begin
                        errors++;
                        if (tg == 6)
                            $display("FAIL R6 n=1 example: got %0d expected %0d", ox1, x);
                        else if (tg == 7)
                            $display("FAIL R7 n=1 top r3: got %0d expected %0d", ox1, x);
                        else if ((x / 4) == 0)
                            $display("FAIL R5 n=1 X=%0d: got %0d expected %0d", x, ox1, x);
                        else
                            $display("FAIL R4 n=1 X=%0d: got %0d expected %0d", x, ox1, x);
                    end
                end else begin
                    checks++;
                    if (ov1 !== 1'b0) begin
                        errors++;
                        $display("FAIL R2 n=1 bubble valid: got %0b expected 0", ov1);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_T * 150000);
        errors++;
        $display("FAIL R2 watchdog: got no completion expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) idle();
        // R1: idle after reset keeps valid low
        checks++;
        if (ov0 !== 1'b0 || ov1 !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset valid: got %0b%0b expected 00", ov0, ov1);
        end

        // R6: worked example (1,2,2) -> 22
        send1(1, 2, 2, 22, 6);
        idle();
        // R7: top value of r3 (1,0,4) -> 4
        send1(1, 0, 4, 4, 7);
        idle();

        // R4 / R5: full n=1 range with bubbles
        for (int x = 0; x < 60; x++) begin
            send1(x % 3, x % 4, x % 5, x, 0);
            if (x % 5 == 4) idle();
        end
        idle();

        // R4 / R5 / R3: full n=2 range with bubbles
        for (int x = 0; x < 4080; x++) begin
            send0(x);
            if (x % 7 == 6) idle();
        end
        repeat (3) idle();

        // R8: reset coinciding with a valid input
        @(negedge clk);
        v0 = 1'b1;
        v1 = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        v0 = 1'b0;
        v1 = 1'b0;
        checks++;
        if (ov0 !== 1'b0 || ov1 !== 1'b0) begin
            errors++;
            $display("FAIL R8 reset wins: got %0b%0b expected 00", ov0, ov1);
        end
        rst = 1'b0;
        repeat (3) idle();

        checks++;
        if (q0.size() != 0 || q1.size() != 0) begin
            errors++;
            $display("FAIL R2 drain: got %0d pending expected 0", q0.size() + q1.size());
        end
        summary();
        $finish;
    end
endmodule